// File: doc/BRIEF.md
# Logic and Shift Execution Unit

This unit sits in the execute stage of a 32-bit RISC pipeline and handles one group of instructions: exclusive-or of two registers, exclusive-or with a zero-extended 16-bit immediate, bitwise complement, and three shifts (logical left, logical right and arithmetic right). A shift count comes either from the low five bits of a register operand or from a zero-extended 5-bit field in the instruction. The unit takes the raw 32-bit instruction (first halfword in bits 15:0, second halfword in bits 31:16) and the two register operand values. It decodes only the fields it needs and produces a 32-bit result and the condition flags.

Outputs are registered, so the result and flags appear one clock after the inputs are presented. A flag-write enable marks a recognised instruction and covers the result, OV, S and Z. A separate carry-write enable is raised only by shifts, because the exclusive-or and complement operations leave the carry flag untouched. An instruction this unit does not recognise produces all-zero outputs with both enables low.

There is no state machine: one register stage captures the combined output of the decoder, the logic path and the shifter. The only named conditions are reset, where every output is zero, and run, where each clock loads the outcome of the instruction presented in the previous cycle.

Top module: `lsx_exec_unit`

## Requirements
- R1: When insn bits 10:5 are 001001, the result is reg2 XOR reg1, flag_we is 1 and cy_we is 0.
- R2: When insn bits 10:5 are 110101, the result is reg1 XOR {16'b0, insn[31:16]}, flag_we is 1 and cy_we is 0.
- R3: OV is 0 for every instruction, recognised or not.
- R4: When insn bits 10:5 are 000001, the result is the bitwise complement of reg1, flag_we is 1 and cy_we is 0.
- R5: When insn bits 10:5 are 010110, reg2 is shifted left logically by insn[4:0], and CY is the last bit shifted out. flag_we and cy_we are both 1.
- R6: When insn bits 10:5 are 010100, reg2 is shifted right logically by insn[4:0], and CY is the last bit shifted out.
- R7: When insn bits 10:5 are 010101, reg2 is shifted right arithmetically by insn[4:0], the vacated bits are filled with the original bit 31, and CY is the last bit shifted out.
- R8: When insn bits 10:5 are 111111 and insn[31:16] is 0x00C0, 0x0080 or 0x00A0, the unit performs the left, logical right or arithmetic right shift respectively, with a count of reg1[4:0].
- R9: A shift with a count of 0 returns reg2 unchanged with CY = 0.
- R10: S equals result bit 31 and Z is 1 exactly when the result is zero, for every recognised instruction.
- R11: Any other encoding, including 111111 with another second halfword, gives result 0, all flags 0, and flag_we = cy_we = 0.
- R12: Outputs are zero during reset and reflect the inputs of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Instruction word: first halfword in bits 15:0, second halfword in bits 31:16 |
| reg1_i | input | 32 | Value of the first source register |
| reg2_i | input | 32 | Value of the second source register (shift operand and XOR source) |
| result_o | output | 32 | Value to write back to the destination register |
| cy_o | output | 1 | Carry flag |
| ov_o | output | 1 | Overflow flag |
| s_o | output | 1 | Sign flag |
| z_o | output | 1 | Zero flag |
| flag_we_o | output | 1 | Result, OV, S and Z are to be written |
| cy_we_o | output | 1 | CY is to be written |

## Verification
The bench targets four kinds of error. The first is the carry bit at the count extremes. With a count of 0, CY must be 0 and the operand must pass through unchanged; a shifter that indexes bit 32-n or n-1 without guarding zero would leak a stray operand bit into CY. With a count of 31, a design that is off by one would report the wrong bit. The second is sign fill on arithmetic right shifts of negative operands; a logical fill would clear the upper bits. The third is the zero extension of the 16-bit immediate; sign extension would flip the upper half when bit 15 is set. The fourth is the decoding of register-form shifts. There, only the low five bits of reg1 may count, so a count of 33 must act as 1. A second halfword other than the three listed must be rejected.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

    parameter int DW    = 32;
    parameter int IMM_W = 16;
    localparam int SHW  = $clog2(DW);

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_XOR  = 3'd1,
        OP_XORI = 3'd2,
        OP_NOT  = 3'd3,
        OP_SHL  = 3'd4,
        OP_SHR  = 3'd5,
        OP_SAR  = 3'd6
    } op_e;

    localparam logic [5:0] F_XOR   = 6'b001001;
    localparam logic [5:0] F_XORI  = 6'b110101;
    localparam logic [5:0] F_NOT   = 6'b000001;
    localparam logic [5:0] F_SHL_I = 6'b010110;
    localparam logic [5:0] F_SHR_I = 6'b010100;
    localparam logic [5:0] F_SAR_I = 6'b010101;
    localparam logic [5:0] F_EXT   = 6'b111111;

    localparam logic [15:0] X_SHL = 16'h00C0;
    localparam logic [15:0] X_SHR = 16'h0080;
    localparam logic [15:0] X_SAR = 16'h00A0;

    function automatic logic is_shift(input op_e op);
        return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
    endfunction

endpackage

// File: rtl/lsx_decode.sv
module lsx_decode
    import lsx_pkg::*;
(
    input  logic [31:0] insn,
    output op_e         op,
    output logic        imm_count
);
    logic [5:0]  fcode;
    logic [15:0] ext;

    assign fcode = insn[10:5];
    assign ext   = insn[31:16];

    always_comb begin
        op        = OP_NONE;
        imm_count = 1'b0;
        unique case (fcode)
            F_XOR:   op = OP_XOR;
            F_XORI:  op = OP_XORI;
            F_NOT:   op = OP_NOT;
            F_SHL_I: begin op = OP_SHL; imm_count = 1'b1; end
            F_SHR_I: begin op = OP_SHR; imm_count = 1'b1; end
            F_SAR_I: begin op = OP_SAR; imm_count = 1'b1; end
            F_EXT: begin
                unique case (ext)
                    X_SHL:   op = OP_SHL;
                    X_SHR:   op = OP_SHR;
                    X_SAR:   op = OP_SAR;
                    default: op = OP_NONE;
                endcase
            end
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/lsx_logic.sv
module lsx_logic
    import lsx_pkg::*;
#(
    parameter int W  = DW,
    parameter int IW = IMM_W
) (
    input  op_e          op,
    input  logic [W-1:0] src1,
    input  logic [W-1:0] src2,
    input  logic [IW-1:0] imm,
    output logic [W-1:0] y
);
    logic [W-1:0] imm_zx;

    assign imm_zx = {{(W-IW){1'b0}}, imm};

    always_comb begin
        unique case (op)
            OP_XOR:  y = src2 ^ src1;
            OP_XORI: y = src1 ^ imm_zx;
            OP_NOT:  y = ~src1;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/lsx_shift.sv
module lsx_shift
    import lsx_pkg::*;
#(
    parameter int W = DW,
    localparam int CW = $clog2(W)
) (
    input  op_e          op,
    input  logic [W-1:0] val,
    input  logic [CW-1:0] cnt,
    output logic [W-1:0] y,
    output logic         cy
);
    // one guard bit beside the operand catches the last bit shifted out
    logic [W:0] left_x, right_x, arith_x;

    assign left_x  = {1'b0, val} << cnt;
    assign right_x = {val, 1'b0} >> cnt;
    assign arith_x = $unsigned($signed({val, 1'b0}) >>> cnt);

    always_comb begin
        unique case (op)
            OP_SHL: begin y = left_x[W-1:0];  cy = left_x[W];  end
            OP_SHR: begin y = right_x[W:1];   cy = right_x[0]; end
            OP_SAR: begin y = arith_x[W:1];   cy = arith_x[0]; end
            default: begin y = '0; cy = 1'b0; end
        endcase
    end
endmodule

// File: rtl/lsx_exec_unit.sv
module lsx_exec_unit
    import lsx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] insn_i,
    input  logic [31:0] reg1_i,
    input  logic [31:0] reg2_i,
    output logic [31:0] result_o,
    output logic        cy_o,
    output logic        ov_o,
    output logic        s_o,
    output logic        z_o,
    output logic        flag_we_o,
    output logic        cy_we_o
);
    op_e            op;
    logic           imm_count;
    logic [SHW-1:0] cnt;
    logic [DW-1:0]  logic_y, shift_y, res_d;
    logic           shift_cy;
    logic           known;

    lsx_decode u_dec (
        .insn      (insn_i),
        .op        (op),
        .imm_count (imm_count)
    );

    assign cnt = imm_count ? insn_i[SHW-1:0] : reg1_i[SHW-1:0];

    lsx_logic #(.W(DW), .IW(IMM_W)) u_logic (
        .op   (op),
        .src1 (reg1_i),
        .src2 (reg2_i),
        .imm  (insn_i[31:32-IMM_W]),
        .y    (logic_y)
    );

    lsx_shift #(.W(DW)) u_shift (
        .op  (op),
        .val (reg2_i),
        .cnt (cnt),
        .y   (shift_y),
        .cy  (shift_cy)
    );

    assign known = (op != OP_NONE);
    assign res_d = is_shift(op) ? shift_y : logic_y;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o  <= '0;
            cy_o      <= 1'b0;
            ov_o      <= 1'b0;
            s_o       <= 1'b0;
            z_o       <= 1'b0;
            flag_we_o <= 1'b0;
            cy_we_o   <= 1'b0;
        end else begin
            result_o  <= res_d;
            cy_o      <= is_shift(op) & shift_cy;
            ov_o      <= 1'b0;
            s_o       <= known & res_d[DW-1];
            z_o       <= known & (res_d == '0);
            flag_we_o <= known;
            cy_we_o   <= is_shift(op);
        end
    end
endmodule

// File: rtl/lsx_exec_chk.sv
module lsx_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] insn_i,
    input logic [31:0] reg1_i,
    input logic [31:0] reg2_i,
    input logic [31:0] result_o,
    input logic        cy_o,
    input logic        ov_o,
    input logic        s_o,
    input logic        z_o,
    input logic        flag_we_o,
    input logic        cy_we_o
);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ov_o);

    p_sign_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> (s_o == result_o[31]));

    p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> (z_o == (result_o == 32'd0)));

    p_unknown_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_o |-> (result_o == 32'd0 && !cy_o && !s_o && !z_o && !cy_we_o));

    p_xor_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(insn_i[10:5]) == 6'b001001)
        |-> (result_o == ($past(reg1_i) ^ $past(reg2_i)) && !cy_we_o && flag_we_o));

    p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(insn_i[10:5]) == 6'b010110 && $past(insn_i[4:0]) == 5'd0)
        |-> (result_o == $past(reg2_i) && !cy_o && cy_we_o));
endmodule

bind lsx_exec_unit lsx_exec_chk u_chk (.*);

// File: tb/tb_lsx_exec_unit.sv
module tb_lsx_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_i = '0, reg1_i = '0, reg2_i = '0;
    logic [31:0] result_o;
    logic        cy_o, ov_o, s_o, z_o, flag_we_o, cy_we_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    lsx_exec_unit dut (.*);

    function automatic logic [31:0] mk(input logic [5:0] f, input logic [4:0] lo,
                                       input logic [15:0] hi);
        return {hi, 5'd7, f, lo};
    endfunction

    // behavioural reference: one bit per loop step
    task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic c, output logic fw, output logic cw,
                         output string tag);
        int kind = 0; // 0 none, 1 xor, 2 xori, 3 not, 4 shl, 5 shr, 6 sar
        int n = 0;
        r = 0; c = 0;
        case (ins[10:5])
            6'b001001: kind = 1;
            6'b110101: kind = 2;
            6'b000001: kind = 3;
            6'b010110: begin kind = 4; n = int'(ins[4:0]); end
            6'b010100: begin kind = 5; n = int'(ins[4:0]); end
            6'b010101: begin kind = 6; n = int'(ins[4:0]); end
            6'b111111: begin
                n = int'(a[4:0]);
                if (ins[31:16] == 16'h00C0) kind = 4;
                else if (ins[31:16] == 16'h0080) kind = 5;
                else if (ins[31:16] == 16'h00A0) kind = 6;
            end
            default: kind = 0;
        endcase
        case (kind)
            1: begin r = a ^ b; tag = "R1/R3/R10"; end
            2: begin r = a ^ {16'h0, ins[31:16]}; tag = "R2/R3/R10"; end
            3: begin r = ~a; tag = "R4/R3/R10"; end
            4, 5, 6: begin
                r = b;
                for (int i = 0; i < n; i++) begin
                    if (kind == 4) begin c = r[31]; r = {r[30:0], 1'b0}; end
                    else if (kind == 5) begin c = r[0]; r = {1'b0, r[31:1]}; end
                    else begin c = r[0]; r = {r[31], r[31:1]}; end
                end
                tag = (kind == 4) ? "R5/R3/R10" : (kind == 5) ? "R6/R3/R10" : "R7/R3/R10";
                if (ins[10:5] == 6'b111111) tag = {tag, "/R8"};
                if (n == 0) tag = {tag, "/R9"};
            end
            default: tag = "R11";
        endcase
        fw = (kind != 0);
        cw = (kind >= 4);
    endtask

    task automatic check(input string tag, input logic [31:0] er, input logic ec,
                         input logic es, input logic ez, input logic efw, input logic ecw);
        total++;
        if (result_o !== er || cy_o !== ec || ov_o !== 1'b0 || s_o !== es || z_o !== ez ||
            flag_we_o !== efw || cy_we_o !== ecw) begin
            bad++;
            $display("FAIL %s: got res=%h cy=%b ov=%b s=%b z=%b fw=%b cw=%b exp res=%h cy=%b ov=0 s=%b z=%b fw=%b cw=%b",
                     tag, result_o, cy_o, ov_o, s_o, z_o, flag_we_o, cy_we_o,
                     er, ec, es, ez, efw, ecw);
        end
    endtask

    // drive at falling edge, check one rising edge later (R12 latency)
    task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r; logic c, fw, cw; string tag;
        @(negedge clk);
        insn_i = ins; reg1_i = a; reg2_i = b;
        model(ins, a, b, r, c, fw, cw, tag);
        @(posedge clk); #2;
        check({tag, "/R12"}, r, c, fw & r[31], fw & (r == 0), fw, cw);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        insn_i = mk(6'b001001, 0, 0); reg1_i = 32'hFFFF_0000; reg2_i = 32'h1234_5678;
        #1 check("R12 reset", 0, 0, 0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;

        apply(mk(6'b001001, 0, 0), 32'hF0F0_F0F0, 32'hFF00_FF00);      // R1
        apply(mk(6'b001001, 0, 0), 32'hA5A5_A5A5, 32'hA5A5_A5A5);      // R1 zero
        apply(mk(6'b110101, 0, 16'h8001), 32'h0000_0000, 32'h0);      // R2 zero extension
        apply(mk(6'b110101, 0, 16'hFFFF), 32'h8000_FFFF, 32'h0);      // R2
        apply(mk(6'b000001, 0, 0), 32'hFFFF_FFFF, 32'h0);             // R4 zero
        apply(mk(6'b000001, 0, 0), 32'h0000_0001, 32'h0);             // R4 sign
        apply(mk(6'b010110, 5'd1, 0), 32'h0, 32'h8000_0001);          // R5 carry out
        apply(mk(6'b010110, 5'd31, 0), 32'h0, 32'h0000_0003);         // R5 max count
        apply(mk(6'b010110, 5'd0, 0), 32'h0, 32'hFFFF_FFFF);          // R9
        apply(mk(6'b010100, 5'd4, 0), 32'h0, 32'h8000_0018);          // R6
        apply(mk(6'b010100, 5'd31, 0), 32'h0, 32'hC000_0000);         // R6
        apply(mk(6'b010101, 5'd8, 0), 32'h0, 32'h8000_0080);          // R7 sign fill
        apply(mk(6'b010101, 5'd31, 0), 32'h0, 32'h8000_0000);         // R7
        apply(mk(6'b010101, 5'd0, 0), 32'h0, 32'h8765_4321);          // R9
        apply(mk(6'b111111, 0, 16'h00C0), 32'd33, 32'h4000_0001);     // R8 count 33 -> 1
        apply(mk(6'b111111, 0, 16'h0080), 32'hFFFF_FFE0, 32'h1);      // R8 count 0
        apply(mk(6'b111111, 0, 16'h00A0), 32'd3, 32'hF000_000F);      // R8
        apply(mk(6'b111111, 0, 16'h00C1), 32'd3, 32'hFFFF_FFFF);      // R11
        apply(mk(6'b000000, 0, 0), 32'h1, 32'h2);                     // R11

        for (int k = 0; k < 3000; k++) begin
            logic [5:0] f;
            logic [15:0] hi;
            int sel = int'($urandom_range(0, 10));
            hi = 16'($urandom);
            case (sel)
                0: f = 6'b001001; 1: f = 6'b110101; 2: f = 6'b000001;
                3: f = 6'b010110; 4: f = 6'b010100; 5: f = 6'b010101;
                6: begin f = 6'b111111; hi = 16'h00C0; end
                7: begin f = 6'b111111; hi = 16'h0080; end
                8: begin f = 6'b111111; hi = 16'h00A0; end
                9: f = 6'b111111;
                default: f = 6'($urandom);
            endcase
            apply(mk(f, 5'($urandom), hi), $urandom, (k % 7 == 0) ? 32'h0 : $urandom);
        end
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule